// File: doc/BRIEF.md
# Dual-Channel LVDS Pixel Router

This block sits between up to four parallel display timing sources and two LVDS transmit channels. Each cycle of `clk` is one pixel period of the sources. For each channel the block picks one source, packs its 24-bit RGB pixel and its sync flags into four 7-bit lane words, and flags each word with a valid strobe. A downstream 7:1 serializer consumes these words. The serializer, the PHY and the clock generation lie outside the block.

A control word enables each channel and sets its colour depth and lane ordering. It also sets the vsync polarity of each display interface and a split option. In split mode one source's line is dealt across both channels, so that each channel runs at half the pixel rate. Setting both channels to the same source gives a duplicated (dual) output, and different sources give independent outputs. Routing and format settings are held in a per-channel shadow. The shadow is loaded only when the normalised vsync of the channel's newly selected source rises, so a change never tears a frame. A control word of zero shuts both channels down at once.

Top module: `lvds_dual_router`

## Requirements
- R1: Channel 0 mode is `ctrl_word[1:0]` and channel 1 mode is `ctrl_word[3:2]`. Values 01 and 11 enable the channel. Values 00 and 10 disable it, and a disabled channel outputs all-zero lanes with its valid low.
- R2: `route_sel[1:0]` (channel 0) and `route_sel[3:2]` (channel 1) pick source 0..3. The source's pixel is at `src_rgb[24*s+23:24*s]` as {R[7:0],G[7:0],B[7:0]}. A pixel presented in one cycle appears on the lanes after the next rising clock edge.
- R3: `ctrl_word[5]` (channel 0) and `ctrl_word[7]` (channel 1) select 24-bit packing when 1. Lane k is `chN_lanes[7k+6:7k]`. The words are lane0={gu[0],ru[5:0]}, lane1={bu[1:0],gu[5:1]}, lane2={de,vs,hs,bu[5:2]} and lane3={0,bl,gl,rl}. Here xu is a 6-bit part and xl a 2-bit part of each component.
- R4: In 18-bit mode (width bit 0) each xu is component[7:2], lane3 is all zero, and the mapping bit has no effect.
- R5: `ctrl_word[6]` (channel 0) and `ctrl_word[8]` (channel 1) choose the 24-bit mapping. With 1, xu=x[7:2] and xl=x[1:0]. With 0, xu=x[5:0] and xl=x[7:6].
- R6: `ctrl_word[9]` and `ctrl_word[10]` mark display interface 0 (sources 0, 2) and display interface 1 (sources 1, 3) as having an active-low vsync. Such a vsync is inverted, and the lane2 vs bit carries the active-high form. The polarity bits act at once.
- R7: Mode, width, mapping, route and split settings take effect only in the cycle where the normalised vsync of the channel's pending source rises. Before that cycle the old settings stay in force, including when another source's vsync rises.
- R8: A control word of zero disables both channels after the next edge without waiting for vsync. The cleared settings stay cleared until a later vsync load.
- R9: With both channels enabled on the same source, the two lane words are identical every cycle.
- R10: When `ctrl_word[4]` is set, channel 1 follows channel 0's route. The pixel counter restarts at the rising edge of the source's data-enable. Both channels strobe valid only after odd-indexed pixels. Channel 0 then carries the preceding even pixel and channel 1 the odd pixel, and both use the odd cycle's sync flags.
- R11: After reset both channels are disabled, with zero lanes and valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 11 | Modes, split, widths, mappings, vsync polarities |
| route_sel | input | 4 | Source index per channel |
| src_rgb | input | 96 | Four 24-bit source pixels |
| src_hs | input | 4 | Source hsync |
| src_vs | input | 4 | Source vsync as received |
| src_de | input | 4 | Source data enable |
| ch0_lanes | output | 28 | Channel 0 lane words |
| ch0_valid | output | 1 | Channel 0 word valid |
| ch1_lanes | output | 28 | Channel 1 lane words |
| ch1_valid | output | 1 | Channel 1 word valid |

## Verification
A settings change and a frame boundary meet in the same cycle when a new route is pending and the vsync of the old or the new source rises. The bench pulses each of these in turn and judges from the lane contents which source and packing are in force. A second collision occurs when the vsync that loads split mode falls on the same cycle as pixel counting. Here the bench checks that the first data-enable edge after the load still opens on an even pixel with no valid strobe. The polarity bits change while a vsync edge is arriving, and the lane2 vs bit must follow the inverted form in that same cycle.

// File: rtl/lbr_pkg.sv
// Shared widths, the per-channel settings record and the lane packing
// function. Assumes four sources and four 7-bit lanes per channel.
package lbr_pkg;
    localparam int NUM_SRC = 4;
    localparam int SEL_W   = $clog2(NUM_SRC);
    localparam int PIX_W   = 24;
    localparam int LANE_W  = 7;
    localparam int NUM_LANE = 4;
    localparam int WORD_W  = LANE_W * NUM_LANE;
    localparam int CTRL_W  = 11;

    typedef struct packed {
        logic             en;
        logic             w24;
        logic             jeida;
        logic             split;
        logic [SEL_W-1:0] src;
    } chan_cfg_t;

    // Packs one pixel plus sync flags into four lane words.
    function automatic logic [WORD_W-1:0] pack_word(
        input logic [PIX_W-1:0] rgb,
        input logic hs, input logic vs, input logic de,
        input logic w24, input logic jeida);
        logic       msb_first;
        logic [5:0] ru, gu, bu;
        logic [1:0] rl, gl, bl;
        logic [LANE_W-1:0] l3;
        msb_first = jeida | ~w24;
        ru = msb_first ? rgb[23:18] : rgb[21:16];
        gu = msb_first ? rgb[15:10] : rgb[13:8];
        bu = msb_first ? rgb[7:2]   : rgb[5:0];
        rl = jeida ? rgb[17:16] : rgb[23:22];
        gl = jeida ? rgb[9:8]   : rgb[15:14];
        bl = jeida ? rgb[1:0]   : rgb[7:6];
        l3 = w24 ? {1'b0, bl, gl, rl} : '0;
        return {l3, {de, vs, hs, bu[5:2]}, {bu[1:0], gu[5:1]}, {gu[0], ru}};
    endfunction
endpackage

// File: rtl/lbr_sync_track.sv
// Normalises every source vsync to active-high using the per-interface
// polarity bits and flags rising edges of vsync and data-enable.
// Assumes source index bit 0 names the display interface.
module lbr_sync_track import lbr_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         vs_low_pol,
    input  logic [NUM_SRC-1:0] src_vs,
    input  logic [NUM_SRC-1:0] src_de,
    output logic [NUM_SRC-1:0] vs_norm,
    output logic [NUM_SRC-1:0] vs_rise,
    output logic [NUM_SRC-1:0] de_rise
);
    logic [NUM_SRC-1:0] vs_d, de_d;

    // Per-source polarity fix-up, one interface bit per source.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_norm
        assign vs_norm[s] = src_vs[s] ^ vs_low_pol[s % 2];
    end

    assign vs_rise = vs_norm & ~vs_d;
    assign de_rise = src_de & ~de_d;

    // Remember last cycle's levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_d <= '0;
            de_d <= '0;
        end else begin
            vs_d <= vs_norm;
            de_d <= src_de;
        end
    end
endmodule

// File: rtl/lbr_split_phase.sv
// Even/odd pixel phase for split mode; a data-enable rising edge forces
// the even phase so every line starts on pixel 0.
module lbr_split_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    output logic odd_now
);
    logic odd_q;

    assign odd_now = line_start ? 1'b0 : odd_q;

    // Alternate the phase every pixel period.
    always_ff @(posedge clk) begin
        if (!rst_n) odd_q <= 1'b0;
        else        odd_q <= ~odd_now;
    end

    assert_line_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> odd_q);
endmodule

// File: rtl/lbr_channel.sv
// One LVDS channel: frame-aligned settings shadow, source mux, split
// even-pixel hold and registered lane packing. ODD_SLOT=1 makes the
// channel carry odd pixels in split mode.
module lbr_channel import lbr_pkg::*; #(
    parameter int ODD_SLOT = 0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  chan_cfg_t                       cfg_pend,
    input  logic                            ctrl_zero,
    input  logic [NUM_SRC-1:0][PIX_W-1:0]   pix,
    input  logic [NUM_SRC-1:0]              hs,
    input  logic [NUM_SRC-1:0]              vs_norm,
    input  logic [NUM_SRC-1:0]              de,
    input  logic [NUM_SRC-1:0]              vs_rise,
    input  logic [NUM_SRC-1:0]              de_rise,
    output logic [WORD_W-1:0]               lanes,
    output logic                            valid
);
    localparam bit TAKES_HELD = (ODD_SLOT == 0);

    chan_cfg_t        act_q, cfg_eff;
    logic             load, odd_now, emit;
    logic [PIX_W-1:0] cur_pix, hold_q, slot_pix;

    assign load = vs_rise[cfg_pend.src];

    // Settings in force this cycle: zero word clears, vsync edge loads.
    always_comb begin
        if (ctrl_zero)  cfg_eff = '0;
        else if (load)  cfg_eff = cfg_pend;
        else            cfg_eff = act_q;
    end

    // Keep the settings in force for the following cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= cfg_eff;
    end

    lbr_split_phase u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (de_rise[cfg_eff.src]),
        .odd_now    (odd_now)
    );

    assign cur_pix  = pix[cfg_eff.src];
    assign slot_pix = (cfg_eff.split && TAKES_HELD) ? hold_q : cur_pix;
    assign emit     = cfg_eff.split ? odd_now : 1'b1;

    // Capture the even pixel of each pair for split output.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= '0;
        else if (!odd_now) hold_q <= cur_pix;
    end

    // Register packed lanes and the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_eff.en) begin
            lanes <= '0;
            valid <= 1'b0;
        end else begin
            valid <= emit;
            if (emit)
                lanes <= pack_word(slot_pix, hs[cfg_eff.src], vs_norm[cfg_eff.src],
                                   de[cfg_eff.src], cfg_eff.w24, cfg_eff.jeida);
        end
    end

    assert_off_is_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_eff.en |=> (!valid && lanes == '0));
    assert_narrow_lane3_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_eff.en && !cfg_eff.w24 && !cfg_eff.split) |=> lanes[WORD_W-1 -: LANE_W] == '0);
    assert_shadow_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_zero && !load) |=> $stable(act_q));
    assert_split_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_eff.en && cfg_eff.split && !odd_now) |=> !valid);
endmodule

// File: rtl/lvds_dual_router.sv
// Top: decodes the control and route words into pending settings for two
// channels and fans the source buses out to them. Channel 1 follows
// channel 0's route while split is requested.
module lvds_dual_router import lbr_pkg::*; (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CTRL_W-1:0]          ctrl_word,
    input  logic [2*SEL_W-1:0]         route_sel,
    input  logic [NUM_SRC*PIX_W-1:0]   src_rgb,
    input  logic [NUM_SRC-1:0]         src_hs,
    input  logic [NUM_SRC-1:0]         src_vs,
    input  logic [NUM_SRC-1:0]         src_de,
    output logic [WORD_W-1:0]          ch0_lanes,
    output logic                       ch0_valid,
    output logic [WORD_W-1:0]          ch1_lanes,
    output logic                       ch1_valid
);
    logic [NUM_SRC-1:0][PIX_W-1:0] pix;
    logic [NUM_SRC-1:0]            vs_norm, vs_rise, de_rise;
    logic                          ctrl_zero, split_req;
    chan_cfg_t                     pend [2];
    logic [WORD_W-1:0]             lanes [2];
    logic                          valid [2];

    assign pix       = src_rgb;
    assign ctrl_zero = (ctrl_word == '0);
    assign split_req = ctrl_word[4];

    lbr_sync_track u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .vs_low_pol (ctrl_word[10:9]),
        .src_vs     (src_vs),
        .src_de     (src_de),
        .vs_norm    (vs_norm),
        .vs_rise    (vs_rise),
        .de_rise    (de_rise)
    );

    // Decode the pending settings of both channels.
    always_comb begin
        pend[0].en    = (ctrl_word[1:0] == 2'b01) || (ctrl_word[1:0] == 2'b11);
        pend[0].w24   = ctrl_word[5];
        pend[0].jeida = ctrl_word[6];
        pend[0].split = split_req;
        pend[0].src   = route_sel[SEL_W-1:0];
        pend[1].en    = (ctrl_word[3:2] == 2'b01) || (ctrl_word[3:2] == 2'b11);
        pend[1].w24   = ctrl_word[7];
        pend[1].jeida = ctrl_word[8];
        pend[1].split = split_req;
        pend[1].src   = split_req ? route_sel[SEL_W-1:0] : route_sel[2*SEL_W-1:SEL_W];
    end

    for (genvar c = 0; c < 2; c++) begin : g_chan
        lbr_channel #(.ODD_SLOT(c)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_pend  (pend[c]),
            .ctrl_zero (ctrl_zero),
            .pix       (pix),
            .hs        (src_hs),
            .vs_norm   (vs_norm),
            .de        (src_de),
            .vs_rise   (vs_rise),
            .de_rise   (de_rise),
            .lanes     (lanes[c]),
            .valid     (valid[c])
        );
    end

    assign ch0_lanes = lanes[0];
    assign ch0_valid = valid[0];
    assign ch1_lanes = lanes[1];
    assign ch1_valid = valid[1];

    assert_zero_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word == '0) |=> (!ch0_valid && !ch1_valid));
endmodule

// File: tb/test_lvds_dual_router.sv
`timescale 1ns/1ps
module test_lvds_dual_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] ctrl_word = '0;
    logic [3:0]  route_sel = '0;
    logic [23:0] px [4];
    logic [3:0]  hs = '0, vs = '0, de = '0;
    logic [27:0] ch0_lanes, ch1_lanes;
    logic        ch0_valid, ch1_valid;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lvds_dual_router i_lvds_dual_router (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .route_sel(route_sel),
        .src_rgb({px[3], px[2], px[1], px[0]}), .src_hs(hs), .src_vs(vs), .src_de(de),
        .ch0_lanes(ch0_lanes), .ch0_valid(ch0_valid),
        .ch1_lanes(ch1_lanes), .ch1_valid(ch1_valid));

    // Arithmetic model of the lane words from the requirement text.
    function automatic logic [27:0] model(input logic [23:0] p, input int h, input int v,
                                          input int d, input int w, input int j);
        int r, g, b, sh, ru, gu, bu, rl, gl, bl, l0, l1, l2, l3;
        r = (p >> 16) & 255; g = (p >> 8) & 255; b = p & 255;
        sh = (j != 0 || w == 0) ? 2 : 0;
        ru = (r >> sh) & 63; gu = (g >> sh) & 63; bu = (b >> sh) & 63;
        rl = (j != 0) ? r & 3 : (r >> 6) & 3;
        gl = (j != 0) ? g & 3 : (g >> 6) & 3;
        bl = (j != 0) ? b & 3 : (b >> 6) & 3;
        l0 = ((gu & 1) << 6) + ru;
        l1 = ((bu & 3) << 5) + (gu >> 1);
        l2 = (d << 6) + (v << 5) + (h << 4) + (bu >> 2);
        l3 = (w != 0) ? (bl << 4) + (gl << 2) + rl : 0;
        return 28'((l3 << 21) + (l2 << 14) + (l1 << 7) + l0);
    endfunction

    function automatic logic [10:0] mk(input int m0, input int m1, input int sp,
        input int w0, input int j0, input int w1, input int j1, input int p0, input int p1);
        return {1'(p1), 1'(p0), 1'(j1), 1'(w1), 1'(j0), 1'(w0), 1'(sp), 2'(m1), 2'(m0)};
    endfunction

    task automatic chk(input string req, input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rand_px();
        for (int s = 0; s < 4; s++) begin
            px[s] = 24'($urandom);
            hs[s] = 1'($urandom);
            de[s] = 1'($urandom);
        end
    endtask

    task automatic pulse_vs(input logic [3:0] mask);
        vs = '0; cyc();
        vs = mask; cyc();
        vs = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [23:0] prev;
        for (int s = 0; s < 4; s++) px[s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        // R11: reset state
        chk("R11 ch0 lanes", ch0_lanes, '0);
        chk("R11 valid", {ch0_valid, ch1_valid}, '0);

        // R2 R3 R4 R5: sweep sources, widths and mappings
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++)
                for (int j = 0; j < 2; j++) begin
                    ctrl_word = mk(3, 1, 0, w, j, w, j, 0, 0);
                    route_sel = {2'(3 - s), 2'(s)};
                    pulse_vs(4'hf);
                    for (int k = 0; k < 3; k++) begin
                        rand_px(); cyc();
                        chk(w == 0 ? "R4 ch0 narrow" : (j != 0 ? "R5 ch0 msb map" : "R3 ch0 wide"),
                            ch0_lanes, model(px[s], hs[s], 0, de[s], w, j));
                        chk("R2 ch1 route", ch1_lanes, model(px[3-s], hs[3-s], 0, de[3-s], w, j));
                        chk("R2 valid", {ch0_valid, ch1_valid}, 28'd3);
                    end
                end

        // R7: settings wait for the new source's vsync
        ctrl_word = mk(1, 0, 0, 1, 0, 0, 0, 0, 0);
        route_sel = 4'b0000;
        pulse_vs(4'hf);
        rand_px(); cyc();
        chk("R7 base", ch0_lanes, model(px[0], hs[0], 0, de[0], 1, 0));
        ctrl_word = mk(1, 0, 0, 0, 0, 0, 0, 0, 0);
        route_sel = 4'b0010;
        rand_px(); cyc();
        chk("R7 no vsync yet", ch0_lanes, model(px[0], hs[0], 0, de[0], 1, 0));
        pulse_vs(4'b0001);
        rand_px(); cyc();
        chk("R7 old source vsync", ch0_lanes, model(px[0], hs[0], 0, de[0], 1, 0));
        pulse_vs(4'b0100);
        rand_px(); cyc();
        chk("R7 new source vsync", ch0_lanes, model(px[2], hs[2], 0, de[2], 0, 0));

        // R1: mode encodings 10 and 00 disable, 11 and 01 enable
        ctrl_word = mk(2, 3, 0, 1, 0, 1, 0, 0, 0);
        route_sel = 4'b1100;
        pulse_vs(4'hf);
        rand_px(); cyc();
        chk("R1 mode 10 lanes", ch0_lanes, '0);
        chk("R1 mode 10 valid", 28'(ch0_valid), '0);
        chk("R1 mode 11", ch1_lanes, model(px[3], hs[3], 0, de[3], 1, 0));
        ctrl_word = mk(1, 0, 0, 1, 0, 1, 0, 0, 0);
        pulse_vs(4'hf);
        rand_px(); cyc();
        chk("R1 mode 00 valid", 28'(ch1_valid), '0);
        chk("R1 mode 01", ch0_lanes, model(px[0], hs[0], 0, de[0], 1, 0));

        // R8: zero word disables at once and stays cleared
        ctrl_word = '0; rand_px(); cyc();
        chk("R8 zero valid", {ch0_valid, ch1_valid}, '0);
        chk("R8 zero lanes", ch0_lanes, '0);
        ctrl_word = mk(1, 1, 0, 1, 1, 1, 1, 0, 0);
        rand_px(); cyc();
        chk("R8 stays off", {ch0_valid, ch1_valid}, '0);
        pulse_vs(4'hf);
        rand_px(); cyc();
        chk("R8 reload", {ch0_valid, ch1_valid}, 28'd3);

        // R9: dual output on one source
        ctrl_word = mk(1, 3, 0, 1, 1, 1, 1, 0, 0);
        route_sel = 4'b0101;
        pulse_vs(4'hf);
        for (int k = 0; k < 4; k++) begin
            rand_px(); cyc();
            chk("R9 identical", ch1_lanes, ch0_lanes);
            chk("R9 content", ch0_lanes, model(px[1], hs[1], 0, de[1], 1, 1));
        end

        // R6: interface 1 vsync active low, interface 0 active high
        ctrl_word = mk(1, 1, 0, 1, 0, 1, 0, 0, 1);
        route_sel = 4'b0001;
        vs = 4'b0010; rand_px(); cyc();
        vs = 4'b0001; rand_px(); cyc();
        chk("R6 inverted high", ch0_lanes, model(px[1], hs[1], 1, de[1], 1, 0));
        chk("R6 plain high", ch1_lanes, model(px[0], hs[0], 1, de[0], 1, 0));
        vs = 4'b0010; rand_px(); cyc();
        chk("R6 inverted low", ch0_lanes, model(px[1], hs[1], 0, de[1], 1, 0));
        chk("R6 plain low", ch1_lanes, model(px[0], hs[0], 0, de[0], 1, 0));
        vs = '0;

        // R10: split across both channels from source 2
        ctrl_word = mk(1, 1, 1, 1, 0, 1, 0, 0, 0);
        route_sel = 4'b0110;
        de = '0; hs = '0;
        pulse_vs(4'b0100);
        repeat (3) cyc();
        de[2] = 1'b1;
        prev = '0;
        for (int k = 0; k < 6; k++) begin
            px[2] = 24'($urandom); cyc();
            if (k % 2 == 1) begin
                chk("R10 odd valid", {ch0_valid, ch1_valid}, 28'd3);
                chk("R10 ch0 even pixel", ch0_lanes, model(prev, 0, 0, 1, 1, 0));
                chk("R10 ch1 odd pixel", ch1_lanes, model(px[2], 0, 0, 1, 1, 0));
            end else begin
                chk("R10 even gap", {ch0_valid, ch1_valid}, '0);
            end
            prev = px[2];
        end

        finish_run();
    end
endmodule